// File: doc/BRIEF.md
# Comparator Event Interrupt Control Register

This block is one 8-bit control and status register for an on-chip analog comparator, together with the logic that turns comparator activity into an interrupt request. The comparator's digital result arrives asynchronously. It is brought into the clock domain through a chain of flops. The chain then feeds an edge detector, a sticky event flag and the bit that shows the live comparator level. The CPU reaches the register through a simple address, write-enable and data bus. Reads are combinational.

Software picks which comparator transitions count as events. Events can be any change, falling only or rising only, and one code is reserved and detects nothing. Software can also power the comparator down and switch its positive input to a fixed internal reference. The flag drives an interrupt request once both the local enable and the CPU's global enable are on. The flag is cleared either by software writing a one to it, or by the interrupt controller's acknowledge strobe when the vector is taken.

Top module: `cmp_irq_ctl`

## Requirements
- R1: When the bus address equals REG_ADDR, the read data is {pd(7), ref(6), live level(5), flag(4), irq enable(3), 0(2), mode(1:0)}. Any other address reads zero.
- R2: Bit 5 and bit 2 are read-only. A write never changes them: bit 5 always shows the synchronized comparator level, and bit 2 always reads 0.
- R3: A change on the asynchronous comparator input shows up in bit 5 after SYNC_STAGES rising clock edges. The flag set by that change shows up one edge later.
- R4: Mode code 00 flags every change of the synchronized level. Code 10 flags only 1-to-0 changes. Code 11 flags only 0-to-1 changes.
- R5: While bit 7 (power-down) is 1, or while mode code 01 is selected, no event is detected and the flag is not set.
- R6: A register write with data bit 4 set to 1 clears the flag. A write with bit 4 set to 0 leaves the flag unchanged.
- R7: One cycle of the acknowledge strobe clears the flag.
- R8: If an event and a clear (a write-one or an acknowledge) fall in the same cycle, the flag ends up at 1.
- R9: The interrupt request is 1 exactly when the flag, bit 3 and the global enable input are all 1.
- R10: After reset, bits 7, 6, 4, 3 and 1:0 are 0, the interrupt request is 0 and both control outputs are 0.
- R11: The power-down output follows bit 7. The reference-select output follows bit 6, where 1 selects the internal reference and 0 selects the external pin. Both outputs may change at any write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_async_i | input | 1 | Raw comparator result, asynchronous |
| bus_addr_i | input | ADDR_W | Register bus address |
| bus_we_i | input | 1 | Register bus write strobe |
| bus_wdata_i | input | 8 | Register bus write data |
| bus_rdata_o | output | 8 | Register bus read data (combinational) |
| gie_i | input | 1 | Global interrupt enable from the CPU |
| irq_ack_i | input | 1 | Vector-taken acknowledge strobe for this source |
| irq_o | output | 1 | Interrupt request |
| cmp_pd_o | output | 1 | Comparator power-down |
| ref_sel_o | output | 1 | Positive-input select: 1 internal reference, 0 pin |

## Verification
The bench builds the block with ADDR_W=6, REG_ADDR=8, SYNC_STAGES=2 and zeroed reads of unselected addresses. With two synchronizer stages, the exact edges at which bit 5 and then the flag change can be pinned down, as R3 requires. It also makes it possible to line up a write-one or an acknowledge with the very cycle in which an event is detected, which is the priority case. With the read zeroing on, one access to a neighbouring address shows that the register decodes only its own address.

// File: rtl/cmp_irq_pkg.sv
`timescale 1ns/1ps
package cmp_irq_pkg;

   // Bit positions in the register; software decodes these.
   localparam int unsigned BIT_PD    = 7;
   localparam int unsigned BIT_REF   = 6;
   localparam int unsigned BIT_LVL   = 5;
   localparam int unsigned BIT_FLAG  = 4;
   localparam int unsigned BIT_IE    = 3;
   localparam int unsigned BIT_RSVD  = 2;
   localparam int unsigned MODE_LSB  = 0;
   localparam int unsigned MODE_W    = 2;
   localparam int unsigned REG_W     = 8;

   typedef enum logic [MODE_W-1:0] {
      EVT_ANY  = 2'b00,
      EVT_NONE = 2'b01,
      EVT_FALL = 2'b10,
      EVT_RISE = 2'b11
   } evt_mode_e;

   typedef struct packed {
      logic      pd;
      logic      refsel;
      logic      ie;
      evt_mode_e mode;
   } ctl_t;

   localparam ctl_t CTL_RESET = '{pd: 1'b0, refsel: 1'b0, ie: 1'b0, mode: EVT_ANY};

endpackage

// File: rtl/cmp_irq_sync.sv
`timescale 1ns/1ps
module cmp_irq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      initial $fatal(1, "cmp_irq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cmp_irq_evt.sv
`timescale 1ns/1ps
module cmp_irq_evt
   import cmp_irq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      lvl_i,
   input  evt_mode_e mode_i,
   input  logic      pd_i,
   output logic      evt_o
);
   logic lvl_prev_q;
   logic rose, fell;

   // The previous level keeps tracking even while detection is off,
   // so re-enabling never reports a stale transition.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_prev_q <= 1'b0;
      else        lvl_prev_q <= lvl_i;
   end

   assign rose = lvl_i & ~lvl_prev_q;
   assign fell = ~lvl_i & lvl_prev_q;

   always_comb begin
      evt_o = 1'b0;
      if (!pd_i) begin
         unique case (mode_i)
            EVT_ANY:  evt_o = rose | fell;
            EVT_FALL: evt_o = fell;
            EVT_RISE: evt_o = rose;
            default:  evt_o = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/cmp_irq_flag.sv
`timescale 1ns/1ps
module cmp_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;

   // A hardware set outranks any clear landing in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (set_i) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/cmp_irq_ctl.sv
`timescale 1ns/1ps
module cmp_irq_ctl
   import cmp_irq_pkg::*;
#(
   parameter int unsigned    ADDR_W          = 6,
   parameter logic [ADDR_W-1:0] REG_ADDR     = 6'h08,
   parameter int unsigned    SYNC_STAGES     = 2,
   parameter bit             ZERO_UNSELECTED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_async_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_we_i,
   input  logic [7:0]        bus_wdata_i,
   output logic [7:0]        bus_rdata_o,
   input  logic              gie_i,
   input  logic              irq_ack_i,
   output logic              irq_o,
   output logic              cmp_pd_o,
   output logic              ref_sel_o
);
   if (ADDR_W < 1) begin : g_bad_addr
      initial $fatal(1, "cmp_irq_ctl: ADDR_W must be positive");
   end
   if (REG_W != 8) begin : g_bad_width
      initial $fatal(1, "cmp_irq_ctl: register width must be 8");
   end

   logic       addr_hit;
   logic       wr_hit;
   ctl_t       ctl_q;
   logic       lvl_sync;
   logic       evt;
   logic       flag_q;
   logic       flag_clr;
   logic [7:0] reg_view;

   assign addr_hit = (bus_addr_i == REG_ADDR);
   assign wr_hit   = addr_hit & bus_we_i;

   // Writable control fields.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= CTL_RESET;
      end else if (wr_hit) begin
         ctl_q.pd     <= bus_wdata_i[BIT_PD];
         ctl_q.refsel <= bus_wdata_i[BIT_REF];
         ctl_q.ie     <= bus_wdata_i[BIT_IE];
         ctl_q.mode   <= evt_mode_e'(bus_wdata_i[MODE_LSB +: MODE_W]);
      end
   end

   cmp_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (cmp_async_i),
      .q_o   (lvl_sync)
   );

   cmp_irq_evt u_evt (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (lvl_sync),
      .mode_i (ctl_q.mode),
      .pd_i   (ctl_q.pd),
      .evt_o  (evt)
   );

   assign flag_clr = (wr_hit & bus_wdata_i[BIT_FLAG]) | irq_ack_i;

   cmp_irq_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (evt),
      .clr_i  (flag_clr),
      .flag_o (flag_q)
   );

   always_comb begin
      reg_view                   = '0;
      reg_view[BIT_PD]           = ctl_q.pd;
      reg_view[BIT_REF]          = ctl_q.refsel;
      reg_view[BIT_LVL]          = lvl_sync;
      reg_view[BIT_FLAG]         = flag_q;
      reg_view[BIT_IE]           = ctl_q.ie;
      reg_view[BIT_RSVD]         = 1'b0;
      reg_view[MODE_LSB +: MODE_W] = ctl_q.mode;
   end

   if (ZERO_UNSELECTED) begin : g_rd_gated
      assign bus_rdata_o = addr_hit ? reg_view : 8'h00;
   end else begin : g_rd_open
      assign bus_rdata_o = reg_view;
   end

   assign irq_o     = flag_q & ctl_q.ie & gie_i;
   assign cmp_pd_o  = ctl_q.pd;
   assign ref_sel_o = ctl_q.refsel;
endmodule

// File: rtl/cmp_irq_ctl_chk.sv
`timescale 1ns/1ps
module cmp_irq_ctl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_hit,
   input logic [7:0] wdata,
   input logic       ack,
   input logic       gie,
   input logic       evt,
   input logic       flag,
   input logic       ie,
   input logic       pd_bit,
   input logic [1:0] mode,
   input logic       irq,
   input logic       pd
);
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> flag); // R8
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && wdata[4] && !evt) |=> !flag); // R6
   AST_W0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !wdata[4] && !ack && !evt) |=> $stable(flag)); // R6
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !evt) |=> !flag); // R7
   AST_QUIET_MODES: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_bit || mode == 2'b01) |-> !evt); // R5
   AST_IRQ_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag && ie && gie)); // R9
   AST_IRQ_WHEN_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && ie && gie) |-> irq); // R9
   AST_PD_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (pd == $past(wdata[7]))); // R11
endmodule

bind cmp_irq_ctl cmp_irq_ctl_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_hit (wr_hit),
   .wdata  (bus_wdata_i),
   .ack    (irq_ack_i),
   .gie    (gie_i),
   .evt    (evt),
   .flag   (flag_q),
   .ie     (ctl_q.ie),
   .pd_bit (ctl_q.pd),
   .mode   (ctl_q.mode),
   .irq    (irq_o),
   .pd     (cmp_pd_o)
);

// File: tb/cmp_irq_ctl_test.sv
`timescale 1ns/1ps
module cmp_irq_ctl_test;
   localparam int unsigned AW = 6;
   localparam logic [AW-1:0] RA = 6'h08;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmp_in = 1'b0;
   logic [AW-1:0] addr = RA;
   logic          we = 1'b0;
   logic [7:0]    wdata = 8'h00;
   logic [7:0]    rdata;
   logic          gie = 1'b0;
   logic          ack = 1'b0;
   logic          irq, pd, rsel;

   always #2.5 clk = ~clk;

   cmp_irq_ctl #(.ADDR_W(AW), .REG_ADDR(RA), .SYNC_STAGES(2), .ZERO_UNSELECTED(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .cmp_async_i(cmp_in), .bus_addr_i(addr), .bus_we_i(we),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .gie_i(gie), .irq_ack_i(ack),
      .irq_o(irq), .cmp_pd_o(pd), .ref_sel_o(rsel)
   );

   typedef struct {
      logic [7:0] rd;
      logic       irq;
      logic       pd;
      logic       rs;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   total = 0;
   int   bad = 0;
   bit   finished = 1'b0;

   // Independent model of the register.
   logic       m_pd = 0, m_ref = 0, m_lvl = 0, m_flag = 0, m_ie = 0;
   logic [1:0] m_mode = 2'b00;

   function automatic logic [7:0] model_rd();
      return {m_pd, m_ref, m_lvl, m_flag, m_ie, 1'b0, m_mode};
   endfunction

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic expect_now(string tag);
      exp_t e;
      e.rd  = (addr == RA) ? model_rd() : 8'h00;
      e.irq = m_flag & m_ie & gie;
      e.pd  = m_pd;
      e.rs  = m_ref;
      e.tag = tag;
      q.push_back(e);
      @(negedge clk);
      #1;
   endtask

   task automatic wr(logic [7:0] v);
      addr = RA; we = 1'b1; wdata = v;
      tick();
      we = 1'b0;
      m_pd = v[7]; m_ref = v[6]; m_ie = v[3]; m_mode = v[1:0];
      if (v[4]) m_flag = 1'b0;
   endtask

   function automatic logic model_evt(logic old_l, logic new_l);
      if (m_pd || m_mode == 2'b01 || old_l == new_l) return 1'b0;
      if (m_mode == 2'b00) return 1'b1;
      if (m_mode == 2'b10) return !new_l;
      return new_l;
   endfunction

   task automatic set_cmp(logic v);
      logic e;
      e = model_evt(m_lvl, v);
      cmp_in = v;
      repeat (3) tick();
      m_lvl = v;
      if (e) m_flag = 1'b1;
   endtask

   // Monitor: pops expectations and compares against the ports.
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         total += 4;
         if (rdata !== e.rd) begin
            bad++; $display("FAIL %s rdata act=%h exp=%h", e.tag, rdata, e.rd);
         end
         if (irq !== e.irq) begin
            bad++; $display("FAIL %s irq act=%b exp=%b", e.tag, irq, e.irq);
         end
         if (pd !== e.pd) begin
            bad++; $display("FAIL %s pd act=%b exp=%b", e.tag, pd, e.pd);
         end
         if (rsel !== e.rs) begin
            bad++; $display("FAIL %s refsel act=%b exp=%b", e.tag, rsel, e.rs);
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog act=hung exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick();
      expect_now("R10 reset state");

      addr = RA + 6'd1;
      expect_now("R1 other address reads zero");
      addr = RA;

      // All writable bits set; bit5/bit2 writes ignored, flag cleared path.
      wr(8'hFF);
      expect_now("R2 R11 write all ones");

      // Disabled: rising edge is not flagged; bit 5 still follows.
      set_cmp(1'b1);
      expect_now("R5 powered down, no event");

      wr(8'h0B);
      expect_now("R11 outputs follow clear");
      set_cmp(1'b0);
      expect_now("R4 rise mode ignores fall");

      // Latency: level after two edges, flag one edge later.
      cmp_in = 1'b1;
      tick(); tick();
      m_lvl = 1'b1;
      expect_now("R3 level visible after sync");
      tick();
      m_flag = 1'b1;
      expect_now("R3 R4 flag after rise");

      gie = 1'b1;
      expect_now("R9 request with global enable");
      wr(8'h03);
      expect_now("R9 local enable off");
      wr(8'h0B);
      expect_now("R6 write zero keeps flag");
      wr(8'h1B);
      expect_now("R6 write one clears flag");

      // Falling mode, cleared by acknowledge.
      wr(8'h0A);
      set_cmp(1'b0);
      expect_now("R4 fall mode flags fall");
      ack = 1'b1; tick(); ack = 1'b0;
      m_flag = 1'b0;
      expect_now("R7 acknowledge clears");

      // Any-change mode.
      wr(8'h08);
      set_cmp(1'b1);
      expect_now("R4 any mode rise");
      wr(8'h18);
      set_cmp(1'b0);
      expect_now("R4 any mode fall");

      // Reserved mode detects nothing.
      wr(8'h19);
      set_cmp(1'b1);
      expect_now("R5 reserved mode rise");
      set_cmp(1'b0);
      expect_now("R5 reserved mode fall");

      // Set wins over simultaneous write-one and acknowledge.
      wr(8'h0B);
      cmp_in = 1'b1;
      tick(); tick();
      we = 1'b1; wdata = 8'h1B; ack = 1'b1;
      tick();
      we = 1'b0; ack = 1'b0;
      m_lvl = 1'b1; m_flag = 1'b1;
      expect_now("R8 set beats clear");

      // Attempted writes to bit 5 (as 0) and bit 2.
      wr(8'h0F);
      expect_now("R2 read-only bits kept");

      // Reference select alone.
      wr(8'h4B);
      expect_now("R11 reference select");

      while (q.size() > 0) @(negedge clk);
      #1;
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule